// File: doc/BRIEF.md
# Accumulator Logic, Compare and Rotate Unit

This block holds an accumulator register and four status flags (carry, zero, sign, parity) and applies one operation to them each time its strobe is high at a rising clock edge. The operations are bitwise AND, OR and XOR with a second operand, an unsigned compare, an accumulator invert, a carry set, a carry invert, and four single-bit rotates. Two rotates wrap the accumulator on itself and two pass through the carry flag.

The second operand arrives on one port whatever its source: a register, a memory read or an immediate field. The caller picks the operation with a 4-bit code and raises the strobe for one cycle. The new accumulator and flags appear on the outputs after that clock edge. Compare changes only the flags. Invert and the carry-only operations leave every flag they do not name untouched. The data width is a parameter, and a parameter also selects how the parity is built: a balanced XOR tree or a ripple chain.

Top module: `acc_flag_unit`

## Requirements
- R1: After reset the accumulator is 0 and carry, zero, sign and parity are all 0.
- R2: With the strobe high, code 0 (AND), 1 (OR) or 2 (XOR) replaces the accumulator with the bitwise result of the accumulator and the operand at the next rising edge, and clears carry.
- R3: After codes 0, 1 and 2, zero is 1 exactly when the result is 0, sign equals the result's top bit, and parity is 1 when the result has an even number of one bits.
- R4: Code 3 (compare) leaves the accumulator unchanged. Carry is 1 exactly when the accumulator is below the operand as unsigned numbers, and zero is 1 exactly when they are equal. Sign and parity follow the R3 rules applied to the difference accumulator minus operand, modulo 2^width.
- R5: Code 4 inverts every accumulator bit and leaves all four flags unchanged.
- R6: Code 5 sets carry to 1 and code 6 inverts carry. Both leave the accumulator, zero, sign and parity unchanged.
- R7: Code 7 rotates the accumulator left by one with the top bit moving to bit 0. Code 8 rotates right by one with bit 0 moving to the top bit. In both, carry takes the bit that wrapped round.
- R8: Code 9 shifts left with the old carry entering bit 0 and the old top bit going to carry. Code 10 shifts right with the old carry entering the top bit and the old bit 0 going to carry.
- R9: Codes 7 to 10 leave zero, sign and parity unchanged.
- R10: With the strobe low, or with codes 11 to 15, the accumulator and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: apply op_code at this edge |
| op_code | input | 4 | Operation code, values as in R2 to R10 |
| operand | input | DW | Second operand for logic and compare |
| acc_q | output | DW | Accumulator value |
| flag_cy | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Parity flag (1 = even count of ones) |

## Verification
The assertions check the invariants that hold after every strobe on every cycle. After a logic operation, carry is clear and zero, sign and parity agree with the new accumulator. Compare holds the accumulator and never sets carry and zero together. Invert is exact. A wrapping rotate puts the moved bit into carry, rotates keep zero, sign and parity, and an idle cycle freezes the state. Only the bench's sweeps can show that each result value is correct: the unsigned ordering of the compare at and around equality, the sign and parity of the difference, and the rotates through carry for both carry values over every accumulator value.

// File: rtl/acc_flag_pkg.sv
`timescale 1ns/1ps
package acc_flag_pkg;

   typedef enum logic [3:0] {
      OP_AND  = 4'd0,
      OP_OR   = 4'd1,
      OP_XOR  = 4'd2,
      OP_CMP  = 4'd3,
      OP_CPLA = 4'd4,
      OP_SETC = 4'd5,
      OP_CPLC = 4'd6,
      OP_RLC  = 4'd7,
      OP_RRC  = 4'd8,
      OP_RAL  = 4'd9,
      OP_RAR  = 4'd10
   } acc_op_e;

   typedef struct packed {
      logic cy;
      logic z;
      logic s;
      logic p;
   } acc_flags_t;

endpackage

// File: rtl/acc_bitwise.sv
`timescale 1ns/1ps
module acc_bitwise
   import acc_flag_pkg::*;
#(
   parameter int DW = 8
) (
   input  acc_op_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] res
);

   logic sel_and;
   logic sel_or;
   logic sel_xor;

   assign sel_and = (op == OP_AND);
   assign sel_or  = (op == OP_OR);
   assign sel_xor = (op == OP_XOR);

   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign res[i] = (sel_and & (a[i] & b[i])) |
                      (sel_or  & (a[i] | b[i])) |
                      (sel_xor & (a[i] ^ b[i]));
   end

endmodule

// File: rtl/acc_compare.sv
`timescale 1ns/1ps
module acc_compare #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] diff,
   output logic          borrow
);

   localparam int XW = DW + 1;

   logic [XW-1:0] wide;

   assign wide   = {1'b0, a} - {1'b0, b};
   assign diff   = wide[DW-1:0];
   assign borrow = wide[XW-1];

endmodule

// File: rtl/acc_rotate.sv
`timescale 1ns/1ps
module acc_rotate
   import acc_flag_pkg::*;
#(
   parameter int DW = 8
) (
   input  acc_op_e       op,
   input  logic [DW-1:0] a,
   input  logic          cin,
   output logic [DW-1:0] res,
   output logic          cout
);

   localparam int MSB = DW - 1;

   always_comb begin
      res  = a;
      cout = cin;
      case (op)
         OP_RLC: begin
            res  = {a[MSB-1:0], a[MSB]};
            cout = a[MSB];
         end
         OP_RRC: begin
            res  = {a[0], a[MSB:1]};
            cout = a[0];
         end
         OP_RAL: begin
            res  = {a[MSB-1:0], cin};
            cout = a[MSB];
         end
         OP_RAR: begin
            res  = {cin, a[MSB:1]};
            cout = a[0];
         end
         default: begin
            res  = a;
            cout = cin;
         end
      endcase
   end

endmodule

// File: rtl/acc_parity.sv
`timescale 1ns/1ps
module acc_parity #(
   parameter int DW    = 8,
   parameter bit CHAIN = 1'b0
) (
   input  logic [DW-1:0] v,
   output logic          even
);

   if (DW < 1) begin : g_bad_width
      $error("acc_parity: DW must be at least 1");
   end

   if (CHAIN) begin : g_chain
      logic [DW:0] link;
      assign link[0] = 1'b0;
      for (genvar i = 0; i < DW; i++) begin : g_stage
         assign link[i+1] = link[i] ^ v[i];
      end
      assign even = ~link[DW];
   end else begin : g_tree
      assign even = ~(^v);
   end

endmodule

// File: rtl/acc_flag_unit.sv
`timescale 1ns/1ps
module acc_flag_unit
   import acc_flag_pkg::*;
#(
   parameter int DW           = 8,
   parameter bit PARITY_CHAIN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [3:0]    op_code,
   input  logic [DW-1:0] operand,
   output logic [DW-1:0] acc_q,
   output logic          flag_cy,
   output logic          flag_z,
   output logic          flag_s,
   output logic          flag_p
);

   localparam int MSB = DW - 1;

   if (DW < 2) begin : g_bad_width
      $error("acc_flag_unit: DW must be at least 2");
   end

   acc_op_e       op;
   acc_flags_t    flg_q;
   acc_flags_t    flg_d;
   logic [DW-1:0] acc_d;
   logic [DW-1:0] logic_res;
   logic [DW-1:0] cmp_diff;
   logic          cmp_borrow;
   logic [DW-1:0] rot_res;
   logic          rot_cout;
   logic [DW-1:0] flag_src;
   logic          src_even;

   assign op = acc_op_e'(op_code);

   acc_bitwise #(.DW(DW)) u_bitwise (
      .op  (op),
      .a   (acc_q),
      .b   (operand),
      .res (logic_res)
   );

   acc_compare #(.DW(DW)) u_compare (
      .a      (acc_q),
      .b      (operand),
      .diff   (cmp_diff),
      .borrow (cmp_borrow)
   );

   acc_rotate #(.DW(DW)) u_rotate (
      .op   (op),
      .a    (acc_q),
      .cin  (flg_q.cy),
      .res  (rot_res),
      .cout (rot_cout)
   );

   assign flag_src = (op == OP_CMP) ? cmp_diff : logic_res;

   acc_parity #(.DW(DW), .CHAIN(PARITY_CHAIN)) u_parity (
      .v    (flag_src),
      .even (src_even)
   );

   always_comb begin
      acc_d = acc_q;
      flg_d = flg_q;
      if (op_valid) begin
         case (op)
            OP_AND, OP_OR, OP_XOR: begin
               acc_d    = logic_res;
               flg_d.cy = 1'b0;
               flg_d.z  = ~|flag_src;
               flg_d.s  = flag_src[MSB];
               flg_d.p  = src_even;
            end
            OP_CMP: begin
               flg_d.cy = cmp_borrow;
               flg_d.z  = ~|flag_src;
               flg_d.s  = flag_src[MSB];
               flg_d.p  = src_even;
            end
            OP_CPLA: acc_d    = ~acc_q;
            OP_SETC: flg_d.cy = 1'b1;
            OP_CPLC: flg_d.cy = ~flg_q.cy;
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
               acc_d    = rot_res;
               flg_d.cy = rot_cout;
            end
            default: begin
               acc_d = acc_q;
               flg_d = flg_q;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         flg_q <= '0;
      end else begin
         acc_q <= acc_d;
         flg_q <= flg_d;
      end
   end

   assign flag_cy = flg_q.cy;
   assign flag_z  = flg_q.z;
   assign flag_s  = flg_q.s;
   assign flag_p  = flg_q.p;

   logic is_logic_op;
   logic is_rot_op;
   assign is_logic_op = op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR);
   assign is_rot_op   = op_valid && (op_code == OP_RLC || op_code == OP_RRC ||
                                     op_code == OP_RAL || op_code == OP_RAR);

   AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_n)
      is_logic_op |=> !flag_cy); // R2
   AST_FLAGS_TRACK_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      is_logic_op |=> (flag_z == (acc_q == '0)) && (flag_s == acc_q[MSB]) && (flag_p == ~(^acc_q))); // R3
   AST_CMP_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_CMP) |=> $stable(acc_q) && !(flag_cy && flag_z)); // R4
   AST_CPL_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_CPLA) |=> (acc_q == ~$past(acc_q)) && $stable(flg_q)); // R5
   AST_SETC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_SETC) |=> flag_cy && $stable(acc_q)); // R6
   AST_RLC_WRAP_CY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_RLC) |=> flag_cy == acc_q[0]); // R7
   AST_RRC_WRAP_CY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_RRC) |=> flag_cy == acc_q[MSB]); // R7
   AST_RAL_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_RAL) |=> acc_q[0] == $past(flag_cy)); // R8
   AST_ROT_KEEPS_ZSP: assert property (@(posedge clk) disable iff (!rst_n)
      is_rot_op |=> $stable(flag_z) && $stable(flag_s) && $stable(flag_p)); // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid || op_code > 4'd10) |=> $stable(acc_q) && $stable(flg_q)); // R10

endmodule

// File: tb/acc_flag_unit_test.sv
`timescale 1ns/1ps
module acc_flag_unit_test;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [3:0]    op_code = 4'd0;
   logic [DW-1:0] operand = '0;
   logic [DW-1:0] acc_q;
   logic          flag_cy, flag_z, flag_s, flag_p;

   int n_tests = 0;
   int n_fail  = 0;

   int m_acc = 0;
   int m_cy = 0, m_z = 0, m_s = 0, m_p = 0;

   always #2 clk = ~clk;

   acc_flag_unit #(.DW(DW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_code  (op_code),
      .operand  (operand),
      .acc_q    (acc_q),
      .flag_cy  (flag_cy),
      .flag_z   (flag_z),
      .flag_s   (flag_s),
      .flag_p   (flag_p)
   );

   function automatic int even_ones(input int v);
      int cnt = 0;
      for (int i = 0; i < DW; i++) cnt += (v >> i) % 2;
      return (cnt % 2 == 0) ? 1 : 0;
   endfunction

   function automatic void set_zsp(input int r);
      m_z = (r == 0) ? 1 : 0;
      m_s = r / 128;
      m_p = even_ones(r);
   endfunction

   task automatic check_all(input string tag);
      n_tests++;
      if (int'(acc_q) != m_acc || int'(flag_cy) != m_cy || int'(flag_z) != m_z ||
          int'(flag_s) != m_s || int'(flag_p) != m_p) begin
         n_fail++;
         $display("FAIL %s: acc=%02h cy=%0d z=%0d s=%0d p=%0d expected acc=%02h cy=%0d z=%0d s=%0d p=%0d",
                  tag, acc_q, flag_cy, flag_z, flag_s, flag_p, m_acc, m_cy, m_z, m_s, m_p);
      end
   endtask

   // Update the model for one strobed operation.
   task automatic model(input int op, input int b);
      int a = m_acc;
      int r;
      case (op)
         0: begin r = a & b; m_acc = r; m_cy = 0; set_zsp(r); end
         1: begin r = a | b; m_acc = r; m_cy = 0; set_zsp(r); end
         2: begin r = a ^ b; m_acc = r; m_cy = 0; set_zsp(r); end
         3: begin r = (a - b + 256) % 256; m_cy = (a < b) ? 1 : 0; set_zsp(r); end
         4: m_acc = 255 - a;
         5: m_cy = 1;
         6: m_cy = 1 - m_cy;
         7: begin m_acc = (a * 2) % 256 + a / 128; m_cy = a / 128; end
         8: begin m_acc = a / 2 + (a % 2) * 128; m_cy = a % 2; end
         9: begin m_acc = (a * 2) % 256 + m_cy; m_cy = a / 128; end
         10: begin m_acc = a / 2 + m_cy * 128; m_cy = a % 2; end
         default: ;
      endcase
   endtask

   // Called at a falling edge; returns at the next falling edge after checking.
   task automatic apply(input int op, input int b, input string tag);
      op_valid = 1'b1;
      op_code  = 4'(op);
      operand  = 8'(b);
      model(op, b);
      @(negedge clk);
      op_valid = 1'b0;
      check_all(tag);
   endtask

   task automatic idle(input int op, input int b, input string tag);
      op_valid = 1'b0;
      op_code  = 4'(op);
      operand  = 8'(b);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic load_acc(input int a);
      apply(0, 0, "R2 clear");
      apply(1, a, "R2 load");
   endtask

   initial begin
      #(4 * 190000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset state");

      // Worked values
      load_acc(8'h44); apply(0, 8'h34, "R2 R3 AND 44&34");
      load_acc(8'h3A); apply(1, 8'h8F, "R2 R3 OR 3A|8F");
      load_acc(8'h88); apply(2, 8'hFE, "R2 R3 XOR 88^FE");
      load_acc(8'h57); apply(3, 8'h62, "R4 CMP below");
      load_acc(8'h62); apply(3, 8'h62, "R4 CMP equal");
      load_acc(8'h4F); apply(4, 0, "R5 CPL 4F");
      load_acc(8'hA7); apply(7, 0, "R7 RLC A7");
      load_acc(8'hA7); apply(8, 0, "R7 RRC A7");
      load_acc(8'hA7); apply(10, 0, "R8 RAR A7 cy0");

      // Logic and compare sweep: every accumulator value, sixteen operands each
      for (int a = 0; a < 256; a++) begin
         for (int j = 0; j < 16; j++) begin
            int b = (j == 0) ? a : (j == 1) ? (a + 1) % 256 : (j == 2) ? (a + 255) % 256
                    : (a + j * 37) % 256;
            load_acc(a); apply(0, b, "R2 R3 AND sweep");
            load_acc(a); apply(1, b, "R2 R3 OR sweep");
            load_acc(a); apply(2, b, "R2 R3 XOR sweep");
            load_acc(a); apply(3, b, "R4 CMP sweep");
         end
         load_acc(a); apply(5, 0, "R6 SETC"); apply(4, 0, "R5 CPL keeps flags");
      end

      // Rotates with both carry values
      for (int a = 0; a < 256; a++) begin
         for (int c = 0; c < 2; c++) begin
            for (int op = 7; op <= 10; op++) begin
               load_acc(a);
               if (c == 1) apply(5, 0, "R6 SETC before rotate");
               apply(op, 0, (op < 9) ? "R7 R9 circular rotate" : "R8 R9 rotate through carry");
            end
         end
      end

      // Carry-only operations keep other state
      load_acc(8'h80); apply(5, 0, "R6 SETC");
      apply(6, 0, "R6 CPLC 1->0");
      apply(6, 0, "R6 CPLC 0->1");

      // Ignored cycles
      load_acc(8'h5A); apply(5, 0, "R6 SETC");
      idle(4, 8'hFF, "R10 strobe low CPL");
      idle(0, 8'h00, "R10 strobe low AND");
      for (int op = 11; op < 16; op++) apply(op, 8'h0F, "R10 unused code");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule